// File: doc/BRIEF.md
# Ordered Multi-Engine Route Lookup Dispatcher

This block takes 32-bit IPv4 destination addresses, runs a longest-match style lookup for each one, and returns a 16-bit next-hop code for every address. Addresses are pushed into an internal input queue. Three lookup engines take them in turn, and the results are collected in an internal output queue. A consumer pops results from that queue in exactly the order the addresses arrived.

All three engines read from one shared synchronous SRAM port. That port is split into fixed time slots, not arbitrated cycle by cycle. A free-running six-cycle phase counter gives each engine one issue slot per period. Each engine step takes six cycles: issue the address, wait for the memory, register the read data, spend three cycles on combinational computation, then register the next address. The three engines therefore interleave on the port with no collisions. The block holds a request to an external memory arbiter while any engine has work, and it issues no read until the arbiter grants the port. Table contents and table loading belong to the surrounding system.

The lookup modelled here is a fixed chain of dependent reads. It stands in for a real trie walk, and the ordering and slotting logic around it is the point of the block.

Top module: `lookup_dispatch`

## Requirements
- R1: After an active-low reset, the block shows `in_full`=0, `out_empty`=1, `mem_req`=0 and `mem_rd`=0. A reset applied while results are queued discards them and returns engines and dispatch/drain pointers to engine 0.
- R2: Each lookup makes STEPS (default 3) dependent reads. The first address is `dest[ADDR_W-1:0]`. Each later address is `data[ADDR_W-1:0] ^ dest[31:32-ADDR_W]`, using the previous read's data. The next hop is `data[31:16]^data[15:0]^dest[31:16]^dest[15:0]` of the last read.
- R3: Next hops appear at `out_hop` in the order their addresses were accepted, even when a later engine finishes before an earlier one.
- R4: The port carries at most one read per cycle, and never two reads in consecutive cycles. A single lookup makes exactly STEPS reads. Engines take addresses in rotation 0, 1, 2.
- R5: `mem_req` is high while any engine holds an unfinished lookup and low once every engine is idle or finished. No read (`mem_rd`=1) happens while `mem_gnt` is low.
- R6: A push while `in_full` is high is dropped. With the grant withheld, exactly 3 + IN_DEPTH addresses are accepted.
- R7: While the output queue is full, no new address is dispatched and finished engines hold their results. After the consumer drains the queue, every held result is delivered in order.
- R8: A pop while `out_empty` is high has no effect on later results.
- R9: The block only reads: `mem_we` stays 0 and `mem_wdata` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_push | input | 1 | Push `in_addr` into the input queue |
| in_addr | input | 32 | IPv4 destination address |
| in_full | output | 1 | Input queue full; pushes are dropped |
| out_pop | input | 1 | Remove the head result |
| out_hop | output | 16 | Head next-hop result |
| out_empty | output | 1 | Output queue empty |
| mem_req | output | 1 | Request for the shared SRAM port |
| mem_gnt | input | 1 | Grant from the memory arbiter |
| mem_rd | output | 1 | Read strobe for this cycle |
| mem_we | output | 1 | Write enable, always 0 |
| mem_addr | output | ADDR_W | SRAM address |
| mem_wdata | output | 32 | Write data, always 0 |
| mem_rdata | input | 32 | Read data, valid one cycle after `mem_rd` |

## Verification
The assertions check the slot rules on every cycle:

- Only one engine drives the port at a time.
- Reads never occur back to back.
- Each engine captures data only in the cycle after its own slot.
- No read happens without a grant.
- The engine-idle pattern stays frozen while the output queue is full.
- The input queue never holds more than its depth.

Only the bench scenarios can show the rest. These are that the values from the chained reads are correct, that results stay in arrival order when engines finish out of turn, how many pushes are accepted with the grant withheld, and that a mid-run reset flushes queued results.

// File: rtl/lookup_pkg.sv
package lookup_pkg;
    localparam int NUM_ENG  = 3;
    localparam int CALC_CYC = 3;
    localparam int STEP_CYC = 1 + 1 + CALC_CYC + 1;
    localparam int SLOT     = STEP_CYC / NUM_ENG;
    localparam int PH_W     = $clog2(STEP_CYC);
    localparam int PTR_W    = $clog2(NUM_ENG);
    localparam int DA_W     = 32;
    localparam int NH_W     = 16;
    localparam int MD_W     = 32;

    typedef enum logic [2:0] {
        ENG_IDLE,
        ENG_ISSUE,
        ENG_READ,
        ENG_CALC,
        ENG_DONE
    } eng_st_e;
endpackage

// File: rtl/lk_fifo.sv
module lk_fifo #(
    parameter int W     = 32,
    parameter int DEPTH = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] din,
    output logic         full,
    input  logic         pop,
    output logic [W-1:0] dout,
    output logic         empty
);
    localparam int PW = $clog2(DEPTH);

    typedef struct packed {
        logic [PW:0] wp;
        logic [PW:0] rp;
    } fifo_s;

    fifo_s s_d, s_q;
    logic [W-1:0] mem_q [DEPTH];
    logic         wr_ok;
    logic         rd_ok;

    assign full  = (s_q.wp[PW] != s_q.rp[PW]) && (s_q.wp[PW-1:0] == s_q.rp[PW-1:0]);
    assign empty = (s_q.wp == s_q.rp);
    assign dout  = mem_q[s_q.rp[PW-1:0]];
    assign wr_ok = push && !full;
    assign rd_ok = pop && !empty;

    always_comb begin
        s_d = s_q;
        if (wr_ok) s_d.wp = s_q.wp + 1'b1;
        if (rd_ok) s_d.rp = s_q.rp + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    always_ff @(posedge clk) begin
        if (wr_ok) mem_q[s_q.wp[PW-1:0]] <= din;
    end

    assert_no_overflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.wp - s_q.rp) <= (PW+1)'(DEPTH));
endmodule

// File: rtl/lk_engine.sv
module lk_engine
    import lookup_pkg::*;
#(
    parameter int ADDR_W = 10,
    parameter int STEPS  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [DA_W-1:0]   dest_i,
    input  logic [PH_W-1:0]   rel_i,
    input  logic              gnt_i,
    input  logic [MD_W-1:0]   rdata_i,
    input  logic              ack_i,
    output logic              idle_o,
    output logic              busy_o,
    output logic              done_o,
    output logic              issue_o,
    output logic [ADDR_W-1:0] addr_o,
    output logic [NH_W-1:0]   res_o
);
    localparam int STEP_W = $clog2(STEPS + 1);
    localparam int CNT_W  = $clog2(CALC_CYC + 1);

    typedef struct packed {
        eng_st_e           st;
        logic [STEP_W-1:0] step;
        logic [CNT_W-1:0]  cnt;
        logic [DA_W-1:0]   dest;
        logic [ADDR_W-1:0] addr;
        logic [MD_W-1:0]   data;
        logic [NH_W-1:0]   res;
    } eng_s;

    eng_s s_d, s_q;
    logic [ADDR_W-1:0] next_addr;
    logic [NH_W-1:0]   fold_res;

    // combinational work spread over the CALC_CYC cycles of ENG_CALC
    assign next_addr = s_q.data[ADDR_W-1:0] ^ s_q.dest[DA_W-1 -: ADDR_W];
    assign fold_res  = s_q.data[31:16] ^ s_q.data[15:0] ^ s_q.dest[31:16] ^ s_q.dest[15:0];

    assign idle_o  = (s_q.st == ENG_IDLE);
    assign done_o  = (s_q.st == ENG_DONE);
    assign busy_o  = (s_q.st == ENG_ISSUE) || (s_q.st == ENG_READ) || (s_q.st == ENG_CALC);
    assign issue_o = (s_q.st == ENG_ISSUE) && (rel_i == '0) && gnt_i;
    assign addr_o  = s_q.addr;
    assign res_o   = s_q.res;

    always_comb begin
        s_d = s_q;
        case (s_q.st)
            ENG_IDLE: begin
                if (start_i) begin
                    s_d.st   = ENG_ISSUE;
                    s_d.dest = dest_i;
                    s_d.addr = dest_i[ADDR_W-1:0];
                    s_d.step = '0;
                end
            end
            ENG_ISSUE: begin
                if (issue_o) s_d.st = ENG_READ;
            end
            ENG_READ: begin
                s_d.data = rdata_i;
                s_d.cnt  = '0;
                s_d.st   = ENG_CALC;
            end
            ENG_CALC: begin
                s_d.cnt = s_q.cnt + 1'b1;
                if (s_q.cnt == CNT_W'(CALC_CYC - 1)) begin
                    if (s_q.step == STEP_W'(STEPS - 1)) begin
                        s_d.res = fold_res;
                        s_d.st  = ENG_DONE;
                    end else begin
                        s_d.addr = next_addr;
                        s_d.step = s_q.step + 1'b1;
                        s_d.st   = ENG_ISSUE;
                    end
                end
            end
            ENG_DONE: begin
                if (ack_i) s_d.st = ENG_IDLE;
            end
            default: s_d.st = ENG_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q      <= '0;
            s_q.st   <= ENG_IDLE;
        end else begin
            s_q <= s_d;
        end
    end

    assert_capture_slot_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.st == ENG_READ) |-> (rel_i == PH_W'(1)));
endmodule

// File: rtl/lookup_dispatch.sv
module lookup_dispatch
    import lookup_pkg::*;
#(
    parameter int ADDR_W    = 10,
    parameter int STEPS     = 3,
    parameter int IN_DEPTH  = 4,
    parameter int OUT_DEPTH = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_push,
    input  logic [DA_W-1:0]   in_addr,
    output logic              in_full,
    input  logic              out_pop,
    output logic [NH_W-1:0]   out_hop,
    output logic              out_empty,
    output logic              mem_req,
    input  logic              mem_gnt,
    output logic              mem_rd,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [MD_W-1:0]   mem_wdata,
    input  logic [MD_W-1:0]   mem_rdata
);
    typedef struct packed {
        logic [PH_W-1:0]  ph;
        logic [PTR_W-1:0] dp;
        logic [PTR_W-1:0] rp;
    } ctl_s;

    ctl_s s_d, s_q;

    logic              in_empty;
    logic [DA_W-1:0]   in_head;
    logic              out_full;
    logic              dispatch;
    logic              drain;
    logic [NUM_ENG-1:0] eng_start, eng_ack, eng_idle, eng_busy, eng_done, eng_iss;
    logic [ADDR_W-1:0] eng_addr [NUM_ENG];
    logic [NH_W-1:0]   eng_res  [NUM_ENG];

    lk_fifo #(.W(DA_W), .DEPTH(IN_DEPTH)) u_in_q (
        .clk(clk), .rst_n(rst_n),
        .push(in_push), .din(in_addr), .full(in_full),
        .pop(dispatch), .dout(in_head), .empty(in_empty)
    );

    lk_fifo #(.W(NH_W), .DEPTH(OUT_DEPTH)) u_out_q (
        .clk(clk), .rst_n(rst_n),
        .push(drain), .din(eng_res[s_q.rp]), .full(out_full),
        .pop(out_pop), .dout(out_hop), .empty(out_empty)
    );

    assign dispatch = !in_empty && eng_idle[s_q.dp] && !out_full;
    assign drain    = eng_done[s_q.rp] && !out_full;

    always_comb begin
        s_d = s_q;
        s_d.ph = (s_q.ph == PH_W'(STEP_CYC - 1)) ? '0 : s_q.ph + 1'b1;
        if (dispatch) s_d.dp = (s_q.dp == PTR_W'(NUM_ENG - 1)) ? '0 : s_q.dp + 1'b1;
        if (drain)    s_d.rp = (s_q.rp == PTR_W'(NUM_ENG - 1)) ? '0 : s_q.rp + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    for (genvar e = 0; e < NUM_ENG; e++) begin : g_eng
        localparam int OFF = e * SLOT;
        logic [PH_W-1:0] rel;

        always_comb begin
            if (int'(s_q.ph) >= OFF) rel = PH_W'(int'(s_q.ph) - OFF);
            else                     rel = PH_W'(int'(s_q.ph) + STEP_CYC - OFF);
        end

        assign eng_start[e] = dispatch && (s_q.dp == PTR_W'(e));
        assign eng_ack[e]   = drain    && (s_q.rp == PTR_W'(e));

        lk_engine #(.ADDR_W(ADDR_W), .STEPS(STEPS)) u_eng (
            .clk(clk), .rst_n(rst_n),
            .start_i(eng_start[e]), .dest_i(in_head), .rel_i(rel),
            .gnt_i(mem_gnt), .rdata_i(mem_rdata), .ack_i(eng_ack[e]),
            .idle_o(eng_idle[e]), .busy_o(eng_busy[e]), .done_o(eng_done[e]),
            .issue_o(eng_iss[e]), .addr_o(eng_addr[e]), .res_o(eng_res[e])
        );
    end

    always_comb begin
        mem_addr = '0;
        for (int e = 0; e < NUM_ENG; e++) begin
            if (eng_iss[e]) mem_addr = mem_addr | eng_addr[e];
        end
    end

    assign mem_rd    = |eng_iss;
    assign mem_req   = |eng_busy;
    assign mem_we    = 1'b0;
    assign mem_wdata = '0;

    assert_single_reader_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(eng_iss));
    assert_read_spacing_R4: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd |=> !mem_rd);
    assert_read_needs_grant_R5: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd |-> mem_gnt);
    assert_full_freezes_R7: assert property (@(posedge clk) disable iff (!rst_n)
        out_full |=> $stable(eng_idle));
endmodule

// File: tb/sim_lookup_dispatch.sv
module sim_lookup_dispatch;
    localparam int AW = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_push = 1'b0;
    logic [31:0] in_addr = '0;
    logic        in_full;
    logic        out_pop = 1'b0;
    logic [15:0] out_hop;
    logic        out_empty;
    logic        mem_req;
    logic        mem_gnt = 1'b1;
    logic        mem_rd;
    logic        mem_we;
    logic [AW-1:0] mem_addr;
    logic [31:0] mem_wdata;
    logic [31:0] mem_rdata = '0;

    int checks = 0;
    int failures = 0;
    int rd_cnt = 0;
    int mon_bad = 0;
    bit prev_rd = 1'b0;
    bit finished = 1'b0;
    logic [15:0] exp_q [0:255];
    int wr_i = 0;
    int rd_i = 0;

    always #2 clk = ~clk;

    lookup_dispatch #(.ADDR_W(AW)) u0 (
        .clk(clk), .rst_n(rst_n),
        .in_push(in_push), .in_addr(in_addr), .in_full(in_full),
        .out_pop(out_pop), .out_hop(out_hop), .out_empty(out_empty),
        .mem_req(mem_req), .mem_gnt(mem_gnt), .mem_rd(mem_rd), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
    );

    function automatic logic [31:0] memf(input logic [AW-1:0] a);
        return ({22'd0, a} * 32'h9E3779B1) + 32'h5A5A1234;
    endfunction

    function automatic logic [15:0] ref_hop(input logic [31:0] d);
        logic [AW-1:0] a;
        logic [31:0] v;
        a = d[AW-1:0];
        v = '0;
        for (int k = 0; k < 3; k++) begin
            v = memf(a);
            a = v[AW-1:0] ^ d[31 -: AW];
        end
        return v[31:16] ^ v[15:0] ^ d[31:16] ^ d[15:0];
    endfunction

    always @(posedge clk) begin
        if (mem_rd) mem_rdata <= memf(mem_addr);
    end

    // port monitor for R4, R5, R9
    always @(negedge clk) begin
        if (rst_n) begin
            if (mem_rd) rd_cnt++;
            if (mem_rd && prev_rd) mon_bad++;
            if (mem_rd && !mem_gnt) mon_bad++;
            if (mem_we !== 1'b0 || mem_wdata !== 32'd0) mon_bad++;
            prev_rd = mem_rd;
        end else begin
            prev_rd = 1'b0;
        end
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic push_one(input logic [31:0] a);
        @(negedge clk);
        while (in_full) @(negedge clk);
        in_push = 1'b1;
        in_addr = a;
        exp_q[wr_i[7:0]] = ref_hop(a);
        wr_i++;
        @(negedge clk);
        in_push = 1'b0;
    endtask

    task automatic collect(input int n, input int gap, input string req);
        int got = 0;
        while (got < n) begin
            @(negedge clk);
            if (!out_empty) begin
                chk(out_hop === exp_q[rd_i[7:0]], req, {16'd0, out_hop}, {16'd0, exp_q[rd_i[7:0]]});
                rd_i++;
                got++;
                out_pop = 1'b1;
                @(negedge clk);
                out_pop = 1'b0;
                repeat ((got * 3 + gap) % 5) @(negedge clk);
            end
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        in_push = 1'b0;
        out_pop = 1'b0;
        mem_gnt = 1'b1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        wr_i = 0;
        rd_i = 0;
    endtask

    task automatic t_reset_state();
        do_reset();
        chk(in_full == 1'b0, "R1 in_full", {31'd0, in_full}, 0);
        chk(out_empty == 1'b1, "R1 out_empty", {31'd0, out_empty}, 1);
        chk(mem_req == 1'b0, "R1 mem_req", {31'd0, mem_req}, 0);
        chk(mem_rd == 1'b0, "R1 mem_rd", {31'd0, mem_rd}, 0);
    endtask

    task automatic t_single();
        int r0;
        do_reset();
        r0 = rd_cnt;
        push_one(32'h0ABAC000);
        collect(1, 0, "R2 single lookup");
        chk(rd_cnt - r0 == 3, "R4 reads per lookup", rd_cnt - r0, 3);
        repeat (2) @(negedge clk);
        chk(out_empty == 1'b1, "R2 one result only", {31'd0, out_empty}, 1);
    endtask

    task automatic t_burst_order();
        do_reset();
        fork
            begin
                for (int i = 0; i < 12; i++) begin
                    push_one(32'hDA800000 + i * 32'h01357913);
                    repeat (i % 4) @(negedge clk);
                end
            end
            collect(12, 1, "R3 arrival order");
        join
        chk(mon_bad == 0, "R4 port slot rules", mon_bad, 0);
    endtask

    task automatic t_no_grant();
        int accepted = 0;
        int r0;
        do_reset();
        mem_gnt = 1'b0;
        r0 = rd_cnt;
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            if (!in_full) begin
                exp_q[wr_i[7:0]] = ref_hop(32'h80000000 + i * 32'h00BAA001);
                wr_i++;
                accepted++;
            end
            in_push = 1'b1;
            in_addr = 32'h80000000 + i * 32'h00BAA001;
        end
        @(negedge clk);
        in_push = 1'b0;
        chk(accepted == 7, "R6 accepted with grant low", accepted, 7);
        repeat (40) @(negedge clk);
        chk(mem_req == 1'b1, "R5 request held", {31'd0, mem_req}, 1);
        chk(rd_cnt == r0, "R5 no read before grant", rd_cnt, r0);
        chk(out_empty == 1'b1, "R5 nothing done without grant", {31'd0, out_empty}, 1);
        mem_gnt = 1'b1;
        collect(7, 2, "R6 results after grant");
        repeat (10) @(negedge clk);
        chk(out_empty == 1'b1, "R6 dropped push absent", {31'd0, out_empty}, 1);
    endtask

    task automatic t_out_full();
        do_reset();
        for (int i = 0; i < 10; i++) push_one(32'h0ABAA000 ^ (i * 32'h10203040));
        repeat (200) @(negedge clk);
        chk(out_empty == 1'b0, "R7 results queued", {31'd0, out_empty}, 0);
        chk(mem_req == 1'b0, "R5 request low when engines finished", {31'd0, mem_req}, 0);
        collect(10, 3, "R7 held results in order");
        chk(mon_bad == 0, "R9 read-only port", mon_bad, 0);
    endtask

    task automatic t_empty_pop();
        do_reset();
        @(negedge clk);
        out_pop = 1'b1;
        repeat (3) @(negedge clk);
        out_pop = 1'b0;
        chk(out_empty == 1'b1, "R8 empty after idle pops", {31'd0, out_empty}, 1);
        push_one(32'h12345678);
        push_one(32'hFEDCBA98);
        collect(2, 0, "R8 results after idle pops");
    endtask

    task automatic t_reset_flush();
        do_reset();
        push_one(32'h0A000001);
        push_one(32'h0A000002);
        push_one(32'h0A000003);
        repeat (100) @(negedge clk);
        chk(out_empty == 1'b0, "R1 results present before reset", {31'd0, out_empty}, 0);
        do_reset();
        chk(out_empty == 1'b1, "R1 reset flushes results", {31'd0, out_empty}, 1);
        chk(mem_req == 1'b0, "R1 reset clears engines", {31'd0, mem_req}, 0);
        push_one(32'h0ABAC000);
        collect(1, 0, "R1 lookup after flush");
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            failures++;
            checks++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        t_reset_state();
        t_single();
        t_burst_order();
        t_no_grant();
        t_out_full();
        t_empty_pop();
        t_reset_flush();
        chk(mon_bad == 0, "R4 R5 R9 monitor total", mon_bad, 0);
        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule